// File: doc/BRIEF.md
# Fault Interrupt Hub

This block holds three 32-bit groups of sticky fault flags (loop-0, loop-1 and common) and turns them into interrupt signals and a readable fault index. A one-cycle pulse on a fault event input sets the matching flag. The flag stays set until software writes a 1 to that bit position. Each group is OR-reduced into its own group interrupt. The three group interrupts form a 3-bit bus, and their OR drives a single level interrupt to the CPU.

The 96 flags together also feed a priority encoder. Of all set flags, the one with the lowest position wins, and the encoder reports that position as a 7-bit index. An index of 0 can mean either "no flag set" or "loop-0 bit 0 set". Software resolves this by reading the group interrupt bus or the loop-0 status word.

A simple word-aligned register port exposes the three status words, the group bus and the index for reading. Writes to the status words clear flags.

Top module: `fault_irq_hub`

## Requirements
- R1: After reset every status flag is 0, `grp_irq` is 0, `cpu_irq` is 0 and `fault_idx` is 0.
- R2: A 1 on bit k of `fault_evt` at a rising clock edge sets flag k, visible after that edge. The flag stays set for any number of later cycles without further events.
- R3: A write with `wr_en`=1 to a status word clears exactly those flags whose `wr_data` bit is 1. Flags under a 0 bit keep their value. If an event and a clear hit the same flag in the same cycle, the flag ends set.
- R4: `grp_irq[0]` is the OR of loop-0 flags (`fault_evt` bits 31:0), `grp_irq[1]` is the OR of loop-1 flags (bits 63:32) and `grp_irq[2]` is the OR of common flags (bits 95:64).
- R5: `cpu_irq` is a level signal equal to the OR of the three `grp_irq` bits.
- R6: `fault_idx` is the lowest position (0 to 95) among all set flags, numbered as in R4, so loop-0 bit 0 has the highest priority and common bit 31 the lowest.
- R7: `fault_idx` is 0 both when no flag is set and when only loop-0 bit 0 is set. In the second case `grp_irq[0]`=1, and in the first case `grp_irq`=0.
- R8: Reads at byte address 0x00, 0x04 and 0x08 return the loop-0, loop-1 and common status words. 0x0C returns `grp_irq` in bits 2:0, and 0x10 returns the index in bits 6:0. Unused upper bits read as 0, and any other address, including one whose two low bits are not 0, reads 0.
- R9: Writes to any address other than 0x00, 0x04 and 0x08 change no flag.
- R10: `fault_idx`, `grp_irq` and `cpu_irq` follow the status flags with no added register. They change in the same cycle as the flags they depend on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | 96 | Fault event pulses, one per flag |
| wr_en | input | 1 | Write strobe for flag clearing |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write-one-to-clear mask |
| rd_addr | input | 5 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational |
| grp_irq | output | 3 | Per-group interrupt bus |
| cpu_irq | output | 1 | Combined interrupt to the CPU |
| fault_idx | output | 7 | Priority-encoded index of the winning flag |

## Verification
Single flags are walked across all three groups. This checks that the index numbering and the group bit follow the flag's position, including the group boundaries 31/32 and 63/64 and the extreme 95. Several flags in different groups are then set and cleared from the highest priority down. This shows that the lowest position wins and that the index moves at once to the next remaining flag. A lone loop-0 bit 0 is compared against an empty state to separate the two meanings of index 0. Coincident set and clear, zero-bit writes and writes to non-status addresses show which stimuli leave the flags untouched.

// File: rtl/fault_hub_pkg.sv
package fault_hub_pkg;
  localparam int unsigned GRP_CNT = 3;

  typedef enum logic [2:0] {
    SEL_ST0  = 3'd0,
    SEL_ST1  = 3'd1,
    SEL_STC  = 3'd2,
    SEL_IRQ  = 3'd3,
    SEL_IDX  = 3'd4,
    SEL_NONE = 3'd7
  } rd_sel_e;

  // Byte address to register selection; word-aligned only.
  function automatic rd_sel_e map_word(input logic [31:0] byte_addr);
    rd_sel_e s;
    if (byte_addr[1:0] != 2'b00) begin
      s = SEL_NONE;
    end else begin
      case (byte_addr[31:2])
        30'd0:   s = SEL_ST0;
        30'd1:   s = SEL_ST1;
        30'd2:   s = SEL_STC;
        30'd3:   s = SEL_IRQ;
        30'd4:   s = SEL_IDX;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/fault_sticky_bank.sv
module fault_sticky_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         any_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;

  // Set dominates clear.
  always_comb status_d = (status_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
  assign any_o    = |status_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));

  // R3
  clear_only_by_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/fault_prio_encoder.sv
module fault_prio_encoder #(
  parameter int unsigned VEC_W = 96,
  parameter int unsigned IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);
  // Lowest set position wins; empty vector yields 0.
  function automatic logic [IDX_W-1:0] first_set(input logic [VEC_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    idx_o = first_set(vec_i);
    hit_o = |vec_i;
  end

  // R6
  winner_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> vec_i[idx_o]);

  // R6
  nothing_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((vec_i & ((VEC_W'(1) << idx_o) - VEC_W'(1))) == '0));

  // R7
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (idx_o == '0));
endmodule

// File: rtl/fault_reg_read.sv
module fault_reg_read
  import fault_hub_pkg::*;
#(
  parameter int unsigned GRP_W  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [GRP_CNT*GRP_W-1:0]   status_i,
  input  logic [GRP_CNT-1:0]         grp_irq_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [GRP_W-1:0]           rd_data
);
  rd_sel_e rd_sel;

  always_comb begin
    rd_sel  = map_word(32'(rd_addr));
    rd_data = '0;
    case (rd_sel)
      SEL_ST0: rd_data = status_i[0 +: GRP_W];
      SEL_ST1: rd_data = status_i[GRP_W +: GRP_W];
      SEL_STC: rd_data = status_i[2*GRP_W +: GRP_W];
      SEL_IRQ: rd_data[GRP_CNT-1:0] = grp_irq_i;
      SEL_IDX: rd_data[IDX_W-1:0] = idx_i;
      default: rd_data = '0;
    endcase
  end

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_NONE) |-> (rd_data == '0));

  // R8
  irq_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_IRQ) |-> ((rd_data >> GRP_CNT) == '0));
endmodule

// File: rtl/fault_irq_hub.sv
module fault_irq_hub
  import fault_hub_pkg::*;
#(
  parameter int unsigned GRP_W  = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned VEC_W = GRP_CNT * GRP_W,
  localparam int unsigned IDX_W = $clog2(VEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  fault_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GRP_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [GRP_W-1:0]  rd_data,
  output logic [GRP_CNT-1:0] grp_irq,
  output logic              cpu_irq,
  output logic [IDX_W-1:0]  fault_idx
);
  logic [VEC_W-1:0] status_all;
  logic [VEC_W-1:0] clr_all;
  logic             enc_hit;
  rd_sel_e          wr_sel;

  always_comb wr_sel = map_word(32'(wr_addr));

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_bank
    assign clr_all[g*GRP_W +: GRP_W] =
      (wr_en && (wr_sel == rd_sel_e'(3'(g)))) ? wr_data : '0;

    fault_sticky_bank #(.W(GRP_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (fault_evt[g*GRP_W +: GRP_W]),
      .clr_i    (clr_all[g*GRP_W +: GRP_W]),
      .status_o (status_all[g*GRP_W +: GRP_W]),
      .any_o    (grp_irq[g])
    );
  end

  assign cpu_irq = |grp_irq;

  fault_prio_encoder #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .vec_i (status_all),
    .idx_o (fault_idx),
    .hit_o (enc_hit)
  );

  fault_reg_read #(.GRP_W(GRP_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .status_i  (status_all),
    .grp_irq_i (grp_irq),
    .idx_i     (fault_idx),
    .rd_data   (rd_data)
  );

  // R5
  cpu_matches_encoder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == enc_hit);

  // R9
  stray_write_harmless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_IRQ || wr_sel == SEL_IDX || wr_sel == SEL_NONE))
      |=> ((status_all & $past(status_all)) == $past(status_all)));

  // R4
  grp0_matches_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_irq[0] == (status_all[GRP_W-1:0] != '0));
endmodule

// File: tb/sim_fault_irq_hub.sv
module sim_fault_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] fault_evt = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  grp_irq;
  logic        cpu_irq;
  logic [6:0]  fault_idx;

  int n_chk = 0;
  int n_err = 0;
  logic [95:0] exp_st = '0;

  always #10 clk = ~clk;

  fault_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .grp_irq(grp_irq), .cpu_irq(cpu_irq),
    .fault_idx(fault_idx)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_idx(input logic [95:0] v);
    int k = 0;
    while (k < 96 && !v[k]) k++;
    return (k == 96) ? 32'd0 : 32'(k);
  endfunction

  function automatic logic [2:0] ref_grp(input logic [95:0] v);
    return {v[95:64] != 0, v[63:32] != 0, v[31:0] != 0};
  endfunction

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    chk({req, " grp_irq"}, 32'(grp_irq), 32'(ref_grp(exp_st)));
    chk({req, " cpu_irq"}, 32'(cpu_irq), 32'(exp_st != 0));
    chk({req, " fault_idx"}, 32'(fault_idx), ref_idx(exp_st));
    rd(5'h00, d); chk({req, " R8 loop0 word"}, d, exp_st[31:0]);
    rd(5'h04, d); chk({req, " R8 loop1 word"}, d, exp_st[63:32]);
    rd(5'h08, d); chk({req, " R8 common word"}, d, exp_st[95:64]);
  endtask

  task automatic pulse(input logic [95:0] v);
    @(negedge clk) fault_evt = v;
    @(negedge clk) fault_evt = '0;
    exp_st |= v;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    if (a == 5'h00) exp_st[31:0]  &= ~d;
    if (a == 5'h04) exp_st[63:32] &= ~d;
    if (a == 5'h08) exp_st[95:64] &= ~d;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check_state("R1 reset");
    rd(5'h10, d); chk("R1 index reg after reset", d, 32'd0);
  endtask

  task automatic t_zero_ambiguity;
    pulse(96'd1);
    chk("R7 bit0 idx", 32'(fault_idx), 32'd0);
    chk("R7 bit0 grp", 32'(grp_irq), 32'd1);
    chk("R5 bit0 cpu", 32'(cpu_irq), 32'd1);
    wr(5'h00, 32'h1);
    chk("R7 empty idx", 32'(fault_idx), 32'd0);
    chk("R7 empty grp", 32'(grp_irq), 32'd0);
    check_state("R3 clear bit0");
  endtask

  task automatic t_cross_group;
    logic [31:0] d;
    pulse(96'd1 << 70);
    check_state("R4 common only");
    pulse(96'd1 << 40);
    check_state("R6 loop1 beats common");
    pulse(96'd1 << 5);
    check_state("R6 loop0 beats all");
    rd(5'h0C, d); chk("R8 irq bus word", d, 32'h7);
    rd(5'h10, d); chk("R8 index word", d, 32'd5);
    wr(5'h00, 32'h20);
    chk("R10 idx moves after clear", 32'(fault_idx), 32'd40);
    wr(5'h04, 32'h100);
    chk("R10 idx moves to common", 32'(fault_idx), 32'd70);
    check_state("R3 clear loop1");
    wr(5'h08, 32'h40);
    check_state("R3 clear common");
  endtask

  task automatic t_set_wins;
    pulse((96'd1 << 40) | (96'd1 << 41));
    @(negedge clk) begin
      fault_evt = 96'd1 << 40; wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'h300;
    end
    @(negedge clk) begin fault_evt = '0; wr_en = 1'b0; end
    exp_st[41] = 1'b0;
    check_state("R3 set wins");
    wr(5'h04, 32'h0);
    check_state("R3 zero mask keeps");
    wr(5'h04, 32'hFFFF_FFFF);
    check_state("R3 full clear");
  endtask

  task automatic t_ignored_writes;
    logic [31:0] d;
    pulse((96'd1 << 3) | (96'd1 << 33) | (96'd1 << 90));
    wr(5'h0C, 32'hFFFF_FFFF);
    check_state("R9 write irq addr");
    wr(5'h10, 32'hFFFF_FFFF);
    check_state("R9 write idx addr");
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    check_state("R9 write unmapped");
    rd(5'h14, d); chk("R8 unmapped read", d, 32'd0);
    rd(5'h05, d); chk("R8 unaligned read", d, 32'd0);
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF);
    check_state("R3 wipe all");
  endtask

  task automatic t_sticky;
    pulse(96'd1 << 95);
    repeat (10) @(negedge clk);
    check_state("R2 sticky bit95");
    chk("R6 lowest priority idx", 32'(fault_idx), 32'd95);
    wr(5'h08, 32'h8000_0000);
    check_state("R2 after clear");
  endtask

  task automatic t_walk;
    for (int i = 0; i < 96; i += 7) begin
      pulse(96'd1 << i);
      chk($sformatf("R6 walk idx %0d", i), 32'(fault_idx), 32'(i));
      chk($sformatf("R4 walk grp %0d", i), 32'(grp_irq), 32'(3'b001 << (i / 32)));
      wr(5'(4 * (i / 32)), 32'd1 << (i % 32));
      chk($sformatf("R5 walk cpu off %0d", i), 32'(cpu_irq), 32'd0);
    end
    foreach (exp_st[j]) if (exp_st[j]) $display("model residue at %0d", j);
    pulse((96'd1 << 31) | (96'd1 << 32) | (96'd1 << 63) | (96'd1 << 64));
    check_state("R6 boundary mix");
    wr(5'h00, 32'h8000_0000);
    check_state("R6 boundary drop 31");
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF);
    check_state("R6 boundary clear");
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_ambiguity();
    t_cross_group();
    t_set_wins();
    t_ignored_writes();
    t_sticky();
    t_walk();
    finish_up();
  end
endmodule